// File: doc/BRIEF.md
# SPI Master with Chained Inter-Word Delay

This block is a mode-0 SPI master for words of 2 to 16 bits. After every word it runs a fixed chain of optional idle phases before the next word may begin. First comes a hold phase, during which chip select stays low after the last clock pulse. Next, chip select is released and an optional settle phase follows. Last comes an optional inter-word wait of the programmed gap value plus two module clocks. With all three phases off and a word already queued, the next word follows with chip select held low, so a long stream can be sent in several words.

A host programs the shape of each transfer through a format port. This port sets the clock divider, the word length, the gap length, and the hold and settle counts with their enable bits. The host then writes words through a data/control port. A write marked full-width captures two settings for that word and for later narrow writes: control bit 16, which enables the gap, and the gap length in the format register at that moment. A narrow write supplies only data and reuses the settings captured last. One queued word can wait while a transfer is in progress. It starts on the cycle after the last idle phase ends.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0 and `busy` is 0.
- R2: Each word is sent MSB first. `mosi` changes only when `sclk` falls, and `sclk` idles low. One `sclk` period lasts 2*(`cfg_div`+1) clocks. With the hold phase off, `cs_n` is low for exactly len*2*(`cfg_div`+1) clocks.
- R3: The word length is `cfg_len`, clamped to the range 2 to 16. Only the low len bits of `wr_data` are sent.
- R4: With the gap enabled and the other phases off, `cs_n` stays high for exactly gap+2 clocks between two queued words, where gap is 0 to 63. The gap never lasts fewer than 2 clocks.
- R5: With the gap, hold and settle phases all off and a word queued, the next word starts with no high cycle on `cs_n`.
- R6: With the hold phase on, `cs_n` stays low for `cfg_hold` extra clocks after the last `sclk` pulse, and the later phases follow.
- R7: With the settle phase on, `cs_n` stays high for `cfg_settle` clocks before the gap starts. The high time between words is then settle+gap+2.
- R8: A write with `wr_full`=1 captures `wr_data[16]` as the gap enable, together with the current gap length. A write with `wr_full`=0 reuses the values captured last, whatever its bit 16 holds and whatever the format gap field holds now.
- R9: `busy` is high whenever `cs_n` is low. It stays high through every idle phase and falls when the last phase ends.
- R10: A word written during a transfer waits in a one-entry buffer and starts as soon as the last phase ends. A write made while that buffer is already occupied is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data/control write strobe |
| wr_full | input | 1 | 1 = full-width control write, 0 = data-only write |
| wr_data | input | 32 | Bits 15:0 data, bit 16 gap enable |
| cfg_wr | input | 1 | Format write strobe |
| cfg_div | input | 8 | Clock divider, sclk period 2*(value+1) |
| cfg_len | input | 5 | Word length in bits |
| cfg_gap | input | 6 | Gap length, lasts value+2 clocks |
| cfg_hold_en | input | 1 | Enables the hold phase |
| cfg_hold | input | 8 | Hold phase length in clocks |
| cfg_settle_en | input | 1 | Enables the settle phase |
| cfg_settle | input | 8 | Settle phase length in clocks |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Transfer or idle phase in progress |

## Verification
The hardest case to reach is the latching rule of R8. A narrow write must use gap settings captured on an earlier full write, even after the format gap field has changed. The effect only shows as the high time between two queued words. The stimulus therefore makes a full write, reprograms the gap, and then queues two narrow words back to back. It measures the `cs_n` high run between them, and repeats this with the enable bit cleared to show a continuous stream. The dropped-write case of R10 is reached by slowing the clock divider, so that a third write arrives while the buffer still holds the second word.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_SETTLE,
    ST_GAP
  } phase_e;

  localparam int GAP_EXTRA = 2;
endpackage

// File: rtl/spi_gap_fmt.sv
module spi_gap_fmt #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 6,
  parameter int DLY_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_hold_en,
  input  logic [DLY_W-1:0] cfg_hold,
  input  logic             cfg_settle_en,
  input  logic [DLY_W-1:0] cfg_settle,
  output logic [DIV_W-1:0] f_div,
  output logic [LEN_W-1:0] f_len,
  output logic [GAP_W-1:0] f_gap,
  output logic             f_hold_en,
  output logic [DLY_W-1:0] f_hold,
  output logic             f_settle_en,
  output logic [DLY_W-1:0] f_settle
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(2);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(DATA_W);

  logic [LEN_W-1:0] len_clamped;

  always_comb begin
    if (cfg_len < LEN_MIN)      len_clamped = LEN_MIN;
    else if (cfg_len > LEN_MAX) len_clamped = LEN_MAX;
    else                        len_clamped = cfg_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_div       <= DIV_W'(1);
      f_len       <= LEN_MAX;
      f_gap       <= '0;
      f_hold_en   <= 1'b0;
      f_hold      <= '0;
      f_settle_en <= 1'b0;
      f_settle    <= '0;
    end else if (cfg_wr) begin
      f_div       <= cfg_div;
      f_len       <= len_clamped;
      f_gap       <= cfg_gap;
      f_hold_en   <= cfg_hold_en;
      f_hold      <= cfg_hold;
      f_settle_en <= cfg_settle_en;
      f_settle    <= cfg_settle;
    end
  end
endmodule

// File: rtl/spi_gap_txbuf.sv
module spi_gap_txbuf #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 32,
  parameter int EN_BIT = 16,
  parameter int GAP_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [GAP_W-1:0]  fmt_gap,
  input  logic              take,
  output logic              pend_vld,
  output logic [DATA_W-1:0] pend_word,
  output logic              pend_gap_en,
  output logic [GAP_W-1:0]  pend_gap
);
  logic             lat_en;
  logic [GAP_W-1:0] lat_gap;
  logic             accept;

  assign accept = wr_en && (!pend_vld || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld    <= 1'b0;
      pend_word   <= '0;
      pend_gap_en <= 1'b0;
      pend_gap    <= '0;
      lat_en      <= 1'b0;
      lat_gap     <= '0;
    end else if (accept) begin
      pend_vld  <= 1'b1;
      pend_word <= wr_data[DATA_W-1:0];
      if (wr_full) begin
        lat_en      <= wr_data[EN_BIT];
        lat_gap     <= fmt_gap;
        pend_gap_en <= wr_data[EN_BIT];
        pend_gap    <= fmt_gap;
      end else begin
        pend_gap_en <= lat_en;
        pend_gap    <= lat_gap;
      end
    end else if (take) begin
      pend_vld <= 1'b0;
    end
  end

  AST_FULL_BUF_DROPS: assert property (@(posedge clk) disable iff (rst)
    (pend_vld && !take && wr_en) |=> $stable(pend_word)); // R10
endmodule

// File: rtl/spi_gap_shift.sv
module spi_gap_shift #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic [DIV_W-1:0]  div,
  output logic              sclk,
  output logic              mosi,
  output logic              last
);
  logic              active;
  logic [DATA_W-1:0] sreg;
  logic [LEN_W-1:0]  bits;
  logic [DIV_W-1:0]  dcnt;
  logic [DIV_W-1:0]  div_l;
  logic [LEN_W-1:0]  shamt;
  logic [DATA_W-1:0] aligned;
  logic              half_end;

  assign shamt    = LEN_W'(DATA_W) - len;
  assign aligned  = word << shamt;
  assign half_end = (dcnt == div_l);
  assign last     = active && half_end && sclk && (bits == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sreg   <= '0;
      bits   <= '0;
      dcnt   <= '0;
      div_l  <= '0;
      sclk   <= 1'b0;
      mosi   <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      sreg   <= aligned;
      mosi   <= aligned[DATA_W-1];
      bits   <= len - LEN_W'(1);
      dcnt   <= '0;
      div_l  <= div;
      sclk   <= 1'b0;
    end else if (active) begin
      if (half_end) begin
        dcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bits == '0) begin
            active <= 1'b0;
          end else begin
            bits <= bits - LEN_W'(1);
            sreg <= sreg << 1;
            mosi <= sreg[DATA_W-2];
          end
        end
      end else begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk); // R2
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R2
endmodule

// File: rtl/spi_gap_master.sv
module spi_gap_master #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 32,
  parameter int EN_BIT = 16,
  parameter int LEN_W  = 5,
  parameter int DIV_W  = 8,
  parameter int GAP_W  = 6,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              cfg_wr,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [GAP_W-1:0]  cfg_gap,
  input  logic              cfg_hold_en,
  input  logic [DLY_W-1:0]  cfg_hold,
  input  logic              cfg_settle_en,
  input  logic [DLY_W-1:0]  cfg_settle,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy
);
  import spi_gap_pkg::*;

  localparam int CNT_W = (DLY_W > GAP_W + 1) ? DLY_W : GAP_W + 1;

  logic [DIV_W-1:0]  f_div;
  logic [LEN_W-1:0]  f_len;
  logic [GAP_W-1:0]  f_gap;
  logic              f_hold_en, f_settle_en;
  logic [DLY_W-1:0]  f_hold, f_settle;
  logic              pend_vld, pend_gap_en;
  logic [DATA_W-1:0] pend_word;
  logic [GAP_W-1:0]  pend_gap;
  logic              start, shift_last, adv;
  logic [1:0]        stage;
  phase_e            state, nxt;
  logic [CNT_W-1:0]  cnt, nxt_cnt, gap_load;
  logic              act_gap_en;
  logic [GAP_W-1:0]  act_gap;
  logic              hold_on, settle_on, cnt_one;

  spi_gap_fmt #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DIV_W(DIV_W), .GAP_W(GAP_W),
                .DLY_W(DLY_W)) u_fmt (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_gap(cfg_gap), .cfg_hold_en(cfg_hold_en), .cfg_hold(cfg_hold),
    .cfg_settle_en(cfg_settle_en), .cfg_settle(cfg_settle),
    .f_div(f_div), .f_len(f_len), .f_gap(f_gap), .f_hold_en(f_hold_en),
    .f_hold(f_hold), .f_settle_en(f_settle_en), .f_settle(f_settle));

  spi_gap_txbuf #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .EN_BIT(EN_BIT),
                  .GAP_W(GAP_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_full(wr_full), .wr_data(wr_data),
    .fmt_gap(f_gap), .take(start), .pend_vld(pend_vld), .pend_word(pend_word),
    .pend_gap_en(pend_gap_en), .pend_gap(pend_gap));

  spi_gap_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .word(pend_word), .len(f_len),
    .div(f_div), .sclk(sclk), .mosi(mosi), .last(shift_last));

  assign hold_on   = f_hold_en && (f_hold != '0);
  assign settle_on = f_settle_en && (f_settle != '0);
  assign gap_load  = CNT_W'(act_gap) + CNT_W'(GAP_EXTRA);
  assign cnt_one   = (cnt == CNT_W'(1));

  always_comb begin
    nxt     = state;
    nxt_cnt = cnt;
    start   = 1'b0;
    adv     = 1'b0;
    stage   = 2'd0;
    case (state)
      ST_IDLE: if (pend_vld) begin
        nxt   = ST_SHIFT;
        start = 1'b1;
      end
      ST_SHIFT: if (shift_last) adv = 1'b1;
      ST_HOLD: begin
        stage = 2'd1;
        if (cnt_one) adv = 1'b1;
        else nxt_cnt = cnt - CNT_W'(1);
      end
      ST_SETTLE: begin
        stage = 2'd2;
        if (cnt_one) adv = 1'b1;
        else nxt_cnt = cnt - CNT_W'(1);
      end
      ST_GAP: begin
        stage = 2'd3;
        if (cnt_one) adv = 1'b1;
        else nxt_cnt = cnt - CNT_W'(1);
      end
      default: nxt = ST_IDLE;
    endcase
    if (adv) begin
      if (stage < 2'd1 && hold_on) begin
        nxt     = ST_HOLD;
        nxt_cnt = CNT_W'(f_hold);
      end else if (stage < 2'd2 && settle_on) begin
        nxt     = ST_SETTLE;
        nxt_cnt = CNT_W'(f_settle);
      end else if (stage < 2'd3 && act_gap_en) begin
        nxt     = ST_GAP;
        nxt_cnt = gap_load;
      end else if (pend_vld) begin
        nxt   = ST_SHIFT;
        start = 1'b1;
      end else begin
        nxt = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      act_gap_en <= 1'b0;
      act_gap    <= '0;
      cs_n       <= 1'b1;
      busy       <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= nxt_cnt;
      cs_n  <= !(nxt == ST_SHIFT || nxt == ST_HOLD);
      busy  <= (nxt != ST_IDLE);
      if (start) begin
        act_gap_en <= pend_gap_en;
        act_gap    <= pend_gap;
      end
    end
  end

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n); // R2
  AST_GAP_MIN_TWO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP && $past(state) != ST_GAP) |=> (state == ST_GAP)); // R4
  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy); // R9
endmodule

// File: tb/spi_gap_master_test.sv
module spi_gap_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_full = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic [4:0]  cfg_len = '0;
  logic [5:0]  cfg_gap = '0;
  logic        cfg_hold_en = 1'b0, cfg_settle_en = 1'b0;
  logic [7:0]  cfg_hold = '0, cfg_settle = '0;
  logic        sclk, mosi, cs_n, busy;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  int          nbits, hi_run, lo_run, nhi, nlo, busy_hi_cs_hi, viol;
  int          hi_q[8], lo_q[8];
  logic [63:0] rx;
  bit          armed;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_gap_master uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_full(wr_full), .wr_data(wr_data),
    .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_len(cfg_len), .cfg_gap(cfg_gap),
    .cfg_hold_en(cfg_hold_en), .cfg_hold(cfg_hold),
    .cfg_settle_en(cfg_settle_en), .cfg_settle(cfg_settle),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy));

  always @(negedge clk) begin
    if (!rst) begin
      if (sclk && !prev_sclk) begin
        rx = {rx[62:0], mosi};
        nbits++;
      end
      if (cs_n != prev_cs) begin
        if (!cs_n) begin
          if (armed && nhi < 8) begin hi_q[nhi] = hi_run; nhi++; end
        end else begin
          if (nlo < 8) begin lo_q[nlo] = lo_run; nlo++; end
          armed = 1'b1;
        end
        hi_run = 0;
        lo_run = 0;
      end
      if (cs_n) hi_run++; else lo_run++;
      if (busy && cs_n) busy_hi_cs_hi++;
      if (!cs_n && !busy) viol++;
      prev_cs   = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    nbits = 0; rx = '0; nhi = 0; nlo = 0; armed = 1'b0;
    busy_hi_cs_hi = 0; viol = 0; hi_run = 0; lo_run = 0;
  endtask

  task automatic cfg(input int div, input int len, input int gap,
                     input bit hen, input int hold, input bit sen, input int settle);
    @(negedge clk);
    cfg_div = 8'(div); cfg_len = 5'(len); cfg_gap = 6'(gap);
    cfg_hold_en = hen; cfg_hold = 8'(hold);
    cfg_settle_en = sen; cfg_settle = 8'(settle);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic put(input bit full, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_full = full; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    repeat (3) @(negedge clk);
    while (q < 4) begin
      @(negedge clk);
      if (!busy && cs_n) q++; else q = 0;
    end
  endtask

  task automatic test_reset();
    chk(cs_n === 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk === 1'b0, "R1 sclk", int'(sclk), 0);
    chk(mosi === 1'b0, "R1 mosi", int'(mosi), 0);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
  endtask

  task automatic test_basic();
    cfg(1, 8, 0, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0000_00A5);
    wait_idle();
    chk(nbits == 8, "R2 bit count", nbits, 8);
    chk(rx[7:0] == 8'hA5, "R2 msb-first data", int'(rx[7:0]), 'hA5);
    chk(lo_q[0] == 32, "R2 cs low time", lo_q[0], 32);
    chk(viol == 0, "R9 busy while cs low", viol, 0);
  endtask

  task automatic test_len();
    cfg(0, 12, 0, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0000_F3C5);
    wait_idle();
    chk(nbits == 12 && rx[11:0] == 12'h3C5, "R3 12-bit word", int'(rx[11:0]), 'h3C5);
    cfg(1, 1, 0, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0000_0006);
    wait_idle();
    chk(nbits == 2 && rx[1:0] == 2'b10, "R3 clamp to 2", nbits, 2);
    chk(lo_q[0] == 8, "R3 clamp cs low", lo_q[0], 8);
    cfg(0, 31, 0, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0000_8001);
    wait_idle();
    chk(nbits == 16 && rx[15:0] == 16'h8001, "R3 clamp to 16", nbits, 16);
  endtask

  task automatic test_gap(input int g);
    cfg(0, 4, g, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0001_0009);
    put(1, 32'h0001_0006);
    wait_idle();
    chk(nbits == 8 && rx[7:0] == 8'h96, "R4 two words data", int'(rx[7:0]), 'h96);
    chk(nhi == 1 && hi_q[0] == g + 2, "R4 gap length", hi_q[0], g + 2);
    chk(busy_hi_cs_hi == 2 * (g + 2), "R9 busy through gaps", busy_hi_cs_hi, 2 * (g + 2));
  endtask

  task automatic test_continuous();
    cfg(0, 4, 9, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0000_000C);
    put(0, 32'h0000_0003);
    wait_idle();
    chk(nlo == 1 && lo_q[0] == 16, "R5 unbroken cs low", lo_q[0], 16);
    chk(rx[7:0] == 8'hC3, "R5 stream data", int'(rx[7:0]), 'hC3);
  endtask

  task automatic test_hold_settle();
    cfg(0, 4, 1, 1, 3, 0, 0);
    clear_mon();
    put(1, 32'h0001_0005);
    put(0, 32'h0000_000A);
    wait_idle();
    chk(lo_q[0] == 11, "R6 hold extends cs low", lo_q[0], 11);
    chk(hi_q[0] == 3, "R6 gap after hold", hi_q[0], 3);
    cfg(0, 4, 2, 0, 0, 1, 4);
    clear_mon();
    put(1, 32'h0001_0005);
    put(0, 32'h0000_000A);
    wait_idle();
    chk(lo_q[0] == 8, "R7 settle keeps cs low time", lo_q[0], 8);
    chk(hi_q[0] == 8, "R7 settle then gap", hi_q[0], 8);
    cfg(0, 4, 0, 1, 2, 1, 3);
    clear_mon();
    put(1, 32'h0001_0005);
    put(0, 32'h0000_000A);
    wait_idle();
    chk(lo_q[0] == 10 && hi_q[0] == 5, "R7 hold settle gap order", hi_q[0], 5);
  endtask

  task automatic test_latch();
    cfg(0, 4, 3, 0, 0, 0, 0);
    put(1, 32'h0001_0001);
    wait_idle();
    cfg(0, 4, 10, 0, 0, 0, 0);
    clear_mon();
    put(0, 32'h0000_0002);
    put(0, 32'h0000_0004);
    wait_idle();
    chk(hi_q[0] == 5, "R8 narrow write keeps old gap", hi_q[0], 5);
    clear_mon();
    put(1, 32'h0000_0007);
    put(0, 32'h0001_0008);
    wait_idle();
    chk(nlo == 1, "R8 full write clears enable", nlo, 1);
    clear_mon();
    put(0, 32'h0001_0003);
    put(0, 32'h0001_000C);
    wait_idle();
    chk(nlo == 1, "R8 narrow bit16 ignored", nlo, 1);
    clear_mon();
    put(1, 32'h0001_0001);
    put(0, 32'h0000_0002);
    wait_idle();
    chk(hi_q[0] == 12, "R8 full write takes new gap", hi_q[0], 12);
  endtask

  task automatic test_drop();
    cfg(3, 8, 0, 0, 0, 0, 0);
    clear_mon();
    put(1, 32'h0001_0011);
    put(0, 32'h0000_0022);
    put(0, 32'h0000_0033);
    wait_idle();
    chk(nlo == 2, "R10 third write dropped", nlo, 2);
    chk(nbits == 16 && rx[15:0] == 16'h1122, "R10 queued data", int'(rx[15:0]), 'h1122);
    chk(hi_q[0] == 2, "R10 queued word starts after gap", hi_q[0], 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_basic();
    test_len();
    test_gap(5);
    test_gap(0);
    test_gap(63);
    test_continuous();
    test_hold_settle();
    test_latch();
    test_drop();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
      $finish;
    end
  end
endmodule